// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It runs the sixteen-state test controller from the TMS input on every rising edge of TCK. It holds a 6-bit instruction register and decodes the held instruction into one selected data path. An identification register and a one-bit bypass register live inside the block. The boundary-scan chain and the two debug-bridge registers (address/command and data) live outside it. For those three, the block drives select lines, a boundary-scan mode and common capture, shift and update strobes, and it receives their serial outputs.

Scans move data least-significant bit first. A host drives TMS and TDI while TCK is low. It samples TDO on the rising edge. The last bit of a scan goes in with TMS high, which moves the controller to the Exit1 state. TDO is re-timed on the falling edge of TCK. It carries data only in the two shift states. At all other times it is held low, with `tdo_en` low.

The serial pins carry one bit per TCK edge with no back-pressure: the host owns the timing completely, so no valid/ready handshake applies. The other pins are plain levels.

Top module: `tap_ctrl`

## Requirements
- R1: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset (`tap_state` 0) from any state. `trst_n` low forces that state asynchronously, with `tdo` and `tdo_en` low.
- R2: State changes follow the standard test-controller graph. `tap_state` encodes the states as follows: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR.
- R3: In Test-Logic-Reset the held instruction becomes the identification code (default 1). A 32-bit data scan then returns `ID_VALUE` least-significant bit first.
- R4: Capture-IR loads the pattern 000001 into the 6-bit instruction shifter. A 6-bit instruction scan therefore returns 000001, least-significant bit first.
- R5: The held instruction `instr` changes only on the rising edge that leaves Update-IR, or on entry to Test-Logic-Reset. It does not change in Exit1-IR, Pause-IR or Exit2-IR.
- R6: Code 63, and any code that is not recognised, selects the one-bit bypass register. That register captures 0, so a scan returns 0 followed by TDI delayed by one bit.
- R7: Codes 5, 6 and 7 raise `sel_bsr` and route `bsr_so` to TDO, with `bsr_mode` = 0, 1 and 2 respectively. For every other code, `bsr_mode` is 0.
- R8: Code 2 raises `sel_cmd` and routes `cmd_so`. Code 3 raises `sel_dat` and routes `dat_so`. At most one of the three select lines is high at any time.
- R9: `dr_capture`, `dr_shift` and `dr_update` are high exactly in capture-DR, shift-DR and update-DR respectively.
- R10: TDO changes on the falling TCK edge. `tdo_en` is high only while the controller is in shift-DR or shift-IR, and TDO is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| tap_state | output | 4 | Controller state code (R2) |
| instr | output | IR_W | Held instruction |
| sel_bsr | output | 1 | Boundary-scan chain selected |
| sel_cmd | output | 1 | Bridge address/command register selected |
| sel_dat | output | 1 | Bridge data register selected |
| bsr_mode | output | 2 | 0 sample/preload, 1 extest, 2 intest |
| dr_capture | output | 1 | Capture strobe for the selected data register |
| dr_shift | output | 1 | Shift strobe for the selected data register |
| dr_update | output | 1 | Update strobe for the selected data register |
| bsr_so | input | 1 | Serial output of the boundary-scan chain |
| cmd_so | input | 1 | Serial output of the address/command register |
| dat_so | input | 1 | Serial output of the data register |

## Verification
The bench builds the block with the default 6-bit instruction register and 32-bit identification register, and overrides `ID_VALUE` to 32'hC0DE5A1B. With that pattern, an identification scan shows a bit-order or capture fault at once. The 6-bit width lets a single table walk cover every decoded code, plus two unrecognised codes (0 and 9) that must fall back to bypass. The directed part exercises the reset timing from shift-DR and shift-IR, the partial four-edge walk, and an instruction scan parked in pause-IR, so the update timing is visible at the ports.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    TS_RESET    = 4'd0,  TS_IDLE     = 4'd1,
    TS_DR_SEL   = 4'd2,  TS_DR_CAP   = 4'd3,  TS_DR_SHIFT = 4'd4,
    TS_DR_EXIT1 = 4'd5,  TS_DR_PAUSE = 4'd6,  TS_DR_EXIT2 = 4'd7,
    TS_DR_UPD   = 4'd8,
    TS_IR_SEL   = 4'd9,  TS_IR_CAP   = 4'd10, TS_IR_SHIFT = 4'd11,
    TS_IR_EXIT1 = 4'd12, TS_IR_PAUSE = 4'd13, TS_IR_EXIT2 = 4'd14,
    TS_IR_UPD   = 4'd15
  } tap_state_e;

  typedef enum logic [2:0] {
    PATH_ID, PATH_BYPASS, PATH_BSR, PATH_CMD, PATH_DAT
  } dr_path_e;
endpackage

// File: rtl/tap_state_fsm.sv
module tap_state_fsm
  import tap_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e state_nxt
);
  localparam int RUN_W = $clog2(RESET_RUN + 1);

  always_comb begin
    unique case (state)
      TS_RESET:    state_nxt = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_nxt = tms ? TS_DR_SEL   : TS_IDLE;
      TS_DR_SEL:   state_nxt = tms ? TS_IR_SEL   : TS_DR_CAP;
      TS_DR_CAP:   state_nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_SHIFT: state_nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_EXIT1: state_nxt = tms ? TS_DR_UPD   : TS_DR_PAUSE;
      TS_DR_PAUSE: state_nxt = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
      TS_DR_EXIT2: state_nxt = tms ? TS_DR_UPD   : TS_DR_SHIFT;
      TS_DR_UPD:   state_nxt = tms ? TS_DR_SEL   : TS_IDLE;
      TS_IR_SEL:   state_nxt = tms ? TS_RESET    : TS_IR_CAP;
      TS_IR_CAP:   state_nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_SHIFT: state_nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_EXIT1: state_nxt = tms ? TS_IR_UPD   : TS_IR_PAUSE;
      TS_IR_PAUSE: state_nxt = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
      TS_IR_EXIT2: state_nxt = tms ? TS_IR_UPD   : TS_IR_SHIFT;
      TS_IR_UPD:   state_nxt = tms ? TS_DR_SEL   : TS_IDLE;
      default:     state_nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= state_nxt;
  end

  // run of consecutive TMS-high edges, kept for the reset check only
  logic [RUN_W-1:0] hi_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                        hi_run <= '0;
    else if (!tms)                      hi_run <= '0;
    else if (hi_run != RUN_W'(RESET_RUN)) hi_run <= hi_run + 1'b1;
  end

  assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_run == RUN_W'(RESET_RUN)) |-> (state == TS_RESET));

  assert_idle_hold_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_IDLE && !tms) |=> (state == TS_IDLE));
endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
  import tap_pkg::*;
#(
  parameter int          IR_W      = 6,
  parameter logic [IR_W-1:0] OP_IDCODE = 1,
  parameter logic [IR_W-1:0] OP_CMD    = 2,
  parameter logic [IR_W-1:0] OP_DAT    = 3,
  parameter logic [IR_W-1:0] OP_SAMPLE = 5,
  parameter logic [IR_W-1:0] OP_EXTEST = 6,
  parameter logic [IR_W-1:0] OP_INTEST = 7
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  tap_state_e      state_nxt,
  output logic            ir_so,
  output logic [IR_W-1:0] instr,
  output dr_path_e        path,
  output logic [1:0]      bsr_mode
);
  localparam logic [IR_W-1:0] IR_CAPT   = {{(IR_W-1){1'b0}}, 1'b1};
  localparam logic [IR_W-1:0] OP_BYPASS = '1;

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                   ir_sr <= '0;
    else if (state == TS_IR_CAP)   ir_sr <= IR_CAPT;
    else if (state == TS_IR_SHIFT) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                      instr <= OP_IDCODE;
    else if (state_nxt == TS_RESET)   instr <= OP_IDCODE;
    else if (state == TS_IR_UPD)      instr <= ir_sr;
  end

  assign ir_so = ir_sr[0];

  always_comb begin
    path     = PATH_BYPASS;
    bsr_mode = 2'd0;
    if (instr == OP_IDCODE)      path = PATH_ID;
    else if (instr == OP_CMD)    path = PATH_CMD;
    else if (instr == OP_DAT)    path = PATH_DAT;
    else if (instr == OP_SAMPLE) path = PATH_BSR;
    else if (instr == OP_EXTEST) begin path = PATH_BSR; bsr_mode = 2'd1; end
    else if (instr == OP_INTEST) begin path = PATH_BSR; bsr_mode = 2'd2; end
    else if (instr == OP_BYPASS) path = PATH_BYPASS;
  end

  assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_IR_CAP) |=> (ir_sr == IR_CAPT));

  assert_ir_update_only_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (instr != $past(instr)) |-> ($past(state) == TS_IR_UPD || state == TS_RESET));
endmodule

// File: rtl/tap_serial_out.sv
module tap_serial_out
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4A55_C0DB
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  dr_path_e   path,
  input  logic       ir_so,
  input  logic       bsr_so,
  input  logic       cmd_so,
  input  logic       dat_so,
  output logic       tdo,
  output logic       tdo_en
);
  logic [ID_W-1:0] id_sr;
  logic            byp_q;
  logic            dr_so;
  logic            out_bit;
  logic            in_shift;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) id_sr <= '0;
    else if (path == PATH_ID) begin
      if (state == TS_DR_CAP)        id_sr <= ID_VALUE;
      else if (state == TS_DR_SHIFT) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) byp_q <= 1'b0;
    else if (path == PATH_BYPASS) begin
      if (state == TS_DR_CAP)        byp_q <= 1'b0;
      else if (state == TS_DR_SHIFT) byp_q <= tdi;
    end
  end

  always_comb begin
    unique case (path)
      PATH_ID:  dr_so = id_sr[0];
      PATH_BSR: dr_so = bsr_so;
      PATH_CMD: dr_so = cmd_so;
      PATH_DAT: dr_so = dat_so;
      default:  dr_so = byp_q;
    endcase
  end

  assign in_shift = (state == TS_DR_SHIFT) || (state == TS_IR_SHIFT);
  assign out_bit  = (state == TS_IR_SHIFT) ? ir_so : dr_so;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= in_shift ? out_bit : 1'b0;
      tdo_en <= in_shift;
    end
  end

  assert_tdo_quiet_R10: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);

  assert_bypass_capture_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_DR_CAP && path == PATH_BYPASS) |=> !byp_q);
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              IR_W     = 6,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4A55_C0DB
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  output logic [3:0]      tap_state,
  output logic [IR_W-1:0] instr,
  output logic            sel_bsr,
  output logic            sel_cmd,
  output logic            sel_dat,
  output logic [1:0]      bsr_mode,
  output logic            dr_capture,
  output logic            dr_shift,
  output logic            dr_update,
  input  logic            bsr_so,
  input  logic            cmd_so,
  input  logic            dat_so
);
  tap_state_e state, state_nxt;
  dr_path_e   path;
  logic       ir_so;

  tap_state_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms),
    .state(state), .state_nxt(state_nxt)
  );

  tap_instr_reg #(.IR_W(IR_W)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .state(state), .state_nxt(state_nxt),
    .ir_so(ir_so), .instr(instr), .path(path), .bsr_mode(bsr_mode)
  );

  tap_serial_out #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_out (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .state(state), .path(path), .ir_so(ir_so),
    .bsr_so(bsr_so), .cmd_so(cmd_so), .dat_so(dat_so),
    .tdo(tdo), .tdo_en(tdo_en)
  );

  assign tap_state  = state;
  assign sel_bsr    = (path == PATH_BSR);
  assign sel_cmd    = (path == PATH_CMD);
  assign sel_dat    = (path == PATH_DAT);
  assign dr_capture = (state == TS_DR_CAP);
  assign dr_shift   = (state == TS_DR_SHIFT);
  assign dr_update  = (state == TS_DR_UPD);

  assert_sel_onehot_R8: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({sel_bsr, sel_cmd, sel_dat}));

  assert_reset_selects_id_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET) |-> (path == PATH_ID));

  assert_tdo_en_in_shift_R10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (state == TS_DR_SHIFT || state == TS_IR_SHIFT));

  assert_mode_only_bsr_R7: assert property (@(posedge tck) disable iff (!trst_n)
    !sel_bsr |-> (bsr_mode == 2'd0));
endmodule

// File: tb/tb_tap_ctrl.sv
`timescale 1ns/1ps
module tb_tap_ctrl;
  localparam logic [31:0] IDV = 32'hC0DE_5A1B;
  localparam int NV = 9;
  // {code[5:0], sel{bsr,cmd,dat}[2:0], mode[1:0], kind[1:0]}  kind: 0 id, 1 bypass, 2 external
  localparam logic [12:0] VEC [NV] = '{
    {6'd63, 3'b000, 2'd0, 2'd1},
    {6'd5,  3'b100, 2'd0, 2'd2},
    {6'd6,  3'b100, 2'd1, 2'd2},
    {6'd7,  3'b100, 2'd2, 2'd2},
    {6'd2,  3'b010, 2'd0, 2'd2},
    {6'd3,  3'b001, 2'd0, 2'd2},
    {6'd1,  3'b000, 2'd0, 2'd0},
    {6'd9,  3'b000, 2'd0, 2'd1},
    {6'd0,  3'b000, 2'd0, 2'd1}
  };

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic bsr_so = 1'b0, cmd_so = 1'b0, dat_so = 1'b0;
  logic tdo, tdo_en, sel_bsr, sel_cmd, sel_dat, dr_capture, dr_shift, dr_update;
  logic [3:0] tap_state;
  logic [5:0] instr;
  logic [1:0] bsr_mode;
  int checks = 0, fails = 0;

  always #2 tck = ~tck;

  tap_ctrl #(.ID_VALUE(IDV)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .tap_state(tap_state), .instr(instr), .sel_bsr(sel_bsr), .sel_cmd(sel_cmd),
    .sel_dat(sel_dat), .bsr_mode(bsr_mode), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update),
    .bsr_so(bsr_so), .cmd_so(cmd_so), .dat_so(dat_so)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic scan(input bit is_ir, input int len, input logic [31:0] din,
                      output logic [31:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o);
    if (is_ir) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] dout;
    logic o;
    #9;
    check("R1 reset state", {28'd0, tap_state}, 32'd0);
    check("R10 tdo_en in reset", {31'd0, tdo_en}, 32'd0);
    check("R10 tdo in reset", {31'd0, tdo}, 32'd0);
    check("R3 instr after reset", {26'd0, instr}, 32'd1);
    @(negedge tck); trst_n = 1'b1;
    step(1'b0, 1'b0, o);
    check("R2 idle", {28'd0, tap_state}, 32'd1);
    check("R10 tdo_en idle", {31'd0, tdo_en}, 32'd0);
    scan(1'b0, 32, 32'h0, dout);
    check("R3 id scan", dout, IDV);

    // R9 strobe walk through a data scan
    step(1'b1, 1'b0, o); check("R2 select-DR", {28'd0, tap_state}, 32'd2);
    step(1'b0, 1'b0, o); check("R9 capture", {28'd0, tap_state, dr_capture, dr_shift, dr_update}, {25'd0, 4'd3, 3'b100});
    step(1'b0, 1'b0, o); check("R9 shift", {28'd0, tap_state, dr_capture, dr_shift, dr_update}, {25'd0, 4'd4, 3'b010});
    @(negedge tck); #1; check("R10 tdo_en in shift", {31'd0, tdo_en}, 32'd1);
    step(1'b1, 1'b0, o); check("R2 exit1-DR", {28'd0, tap_state}, 32'd5);
    step(1'b1, 1'b0, o); check("R9 update", {28'd0, tap_state, dr_capture, dr_shift, dr_update}, {25'd0, 4'd8, 3'b001});
    step(1'b0, 1'b0, o); check("R9 idle strobes", {29'd0, dr_capture, dr_shift, dr_update}, 32'd0);

    // table walk over instruction codes
    for (int v = 0; v < NV; v++) begin
      logic [5:0] code; logic [2:0] sel; logic [1:0] mode, kind;
      {code, sel, mode, kind} = VEC[v];
      scan(1'b1, 6, {26'd0, code}, dout);
      check("R4 ir capture pattern", dout, 32'd1);
      check("R5 instr loaded", {26'd0, instr}, {26'd0, code});
      check("R7 R8 selects", {29'd0, sel_bsr, sel_cmd, sel_dat}, {29'd0, sel});
      check("R7 bsr mode", {30'd0, bsr_mode}, {30'd0, mode});
      if (kind == 2'd0) begin
        scan(1'b0, 32, 32'h0, dout);
        check("R3 id via code 1", dout, IDV);
      end else if (kind == 2'd1) begin
        scan(1'b0, 8, 32'hB2, dout);
        check("R6 bypass delay", dout, 32'h164 & 32'hFF);
      end else begin
        {bsr_so, cmd_so, dat_so} = sel;
        scan(1'b0, 4, 32'h0, dout);
        check("R7 R8 route high", dout, 32'hF);
        {bsr_so, cmd_so, dat_so} = ~sel;
        scan(1'b0, 4, 32'h0, dout);
        check("R7 R8 route low", dout, 32'h0);
        {bsr_so, cmd_so, dat_so} = 3'b000;
      end
    end

    // R5: instruction must not change in exit1/pause/exit2/update-IR
    step(1'b1, 1'b0, o); step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < 6; i++) step(i == 5, (6'd3 >> i) & 1'b1, o);
    check("R5 exit1 hold", {22'd0, tap_state, instr}, {22'd0, 4'd12, 6'd0});
    step(1'b0, 1'b0, o);
    check("R5 pause hold", {22'd0, tap_state, instr}, {22'd0, 4'd13, 6'd0});
    step(1'b1, 1'b0, o); step(1'b1, 1'b0, o);
    check("R5 update-IR hold", {22'd0, tap_state, instr}, {22'd0, 4'd15, 6'd0});
    step(1'b0, 1'b0, o);
    check("R5 after update", {26'd0, instr}, 32'd3);
    check("R8 data select", {29'd0, sel_bsr, sel_cmd, sel_dat}, 32'd1);

    // R1 from shift-DR: four edges short of reset, fifth reaches it
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, o);
    check("R2 four TMS high from shift-DR", {28'd0, tap_state}, 32'd9);
    step(1'b1, 1'b0, o);
    check("R1 five TMS high from shift-DR", {28'd0, tap_state}, 32'd0);
    check("R3 instr after TMS reset", {26'd0, instr}, 32'd1);

    // R1 from shift-IR, after loading bypass
    step(1'b0, 1'b0, o);
    scan(1'b1, 6, 32'h3F, dout);
    step(1'b1, 1'b0, o); step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    check("R2 shift-IR", {28'd0, tap_state}, 32'd11);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    check("R1 five TMS high from shift-IR", {28'd0, tap_state}, 32'd0);
    check("R3 id reselected", {26'd0, instr}, 32'd1);
    @(negedge tck); #1;
    check("R10 tdo quiet in reset", {30'd0, tdo_en, tdo}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule